// File: doc/BRIEF.md
# Two-Mode ADSR Envelope Generator

This block computes the attenuation of one synthesis operator over time. It works in 0.1875 dB units. The internal envelope runs from 0 (full loudness) to 256 (48 dB down, silent). A per-operator total level is added to the envelope before the attenuation leaves the block. A key-on strobe starts a note and a key-off strobe ends it. The envelope then moves through attack, decay, an optional hold, and release. Each phase steps at a rate set by a 4-bit code. A sample-rate enable paces all of the stepping.

Two envelope shapes are available. In hold mode the level stops at the sustain level and stays there until key-off. In fade mode the level keeps falling at the release rate after it reaches the sustain level, even while the key is held. Key-off then switches to a fixed slow tail rate. A long-tail flag replaces the key-off release rate with a fixed slow code in both modes. A key-on that arrives before the envelope is silent first drives the level to full scale at a fast fixed rate, and only then starts the new attack. This keeps restarted notes free of clicks.

Top module: `adsr_env_gen`

## Requirements
- R1: After reset, atten is 256 (48 dB in 0.1875 dB units) and idle is 1.
- R2: atten equals the envelope value plus 4 times tot_lvl (0.75 dB per LSB), saturated at 256. It follows tot_lvl in the same cycle.
- R3: Let n be the number of sample_en cycles seen since reset. A moving rate with shift s changes the envelope by one unit on a sample_en cycle when n mod 2^s is 0. The shift is computed from the rate code c and the parameter RATE_BASE (default 2):
  - Attack, c from 2 to 14: RATE_BASE-1+(14-c).
  - Attack, code 15: the envelope jumps to 0 on the next sample_en cycle.
  - Decay and release, c from 2 to 14: RATE_BASE+(14-c).
  - Decay and release, code 15: RATE_BASE-2.
  - Codes 0 and 1: the envelope never moves.
- R4: key_on while idle enters attack. The envelope falls by one unit per step at atk_rate. The step that brings it to 0 enters decay.
- R5: In decay, the envelope rises by one unit per step at dec_rate. Once it is at or above 16 times sus_lvl (24, 12, 6 and 3 dB for bits 3 to 0), the next clock leaves decay.
- R6: With hold_mode=1, decay leads to a hold phase. The envelope stays constant there until a key strobe arrives.
- R7: With hold_mode=0, decay leads to a fade phase. The envelope rises at rel_rate while the key is held, and becomes idle when it reaches 256.
- R8: key_off in attack, decay, hold, fade or restart damping enters release. Release steps at code 6 if long_tail=1. Otherwise it steps at rel_rate if hold_mode=1, and at code 9 if hold_mode=0.
- R9: key_on while not idle enters damping. Damping rises at code 14 to 256 and then enters attack, with idle staying 0.
- R10: key_on has priority over a simultaneous key_off. key_off while idle has no effect.
- R11: Release and fade end in idle in the clock where the envelope reaches 256, including when it is already at 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample-rate enable that paces all envelope steps |
| key_on | input | 1 | Note start strobe |
| key_off | input | 1 | Note end strobe |
| atk_rate | input | 4 | Attack rate code |
| dec_rate | input | 4 | Decay rate code |
| rel_rate | input | 4 | Release rate code |
| sus_lvl | input | 4 | Sustain level, 3 dB per LSB |
| tot_lvl | input | 6 | Total level, 0.75 dB per LSB |
| hold_mode | input | 1 | 1 selects hold at sustain level, 0 selects fade |
| long_tail | input | 1 | Forces the key-off release to code 6 |
| atten | output | 9 | Output attenuation, 0.1875 dB units, 256 is silent |
| idle | output | 1 | Envelope is stopped at full scale |

## Verification
Key strobes and sample_en steps are registered at a rising edge, so atten and idle show their effect one clock after the edge that sampled them. A tot_lvl change reaches atten in the same cycle. Stimulus is driven at the falling edge and every result is compared at the next falling edge against a bench model advanced at the rising edge. This puts each comparison exactly one register stage after its cause. The directed cases count their waits in whole clocks from the driving edge: two clocks for an instant attack, one clock per unit for code 15 decay, and four per unit for restart damping.

// File: rtl/eg_pkg.sv
package eg_pkg;

   typedef enum logic [2:0] {
      EG_IDLE    = 3'd0,
      EG_ATTACK  = 3'd1,
      EG_DECAY   = 3'd2,
      EG_HOLD    = 3'd3,
      EG_FALL    = 3'd4,
      EG_RELEASE = 3'd5,
      EG_DAMP    = 3'd6
   } eg_phase_t;

   localparam int          EG_CODE_W    = 4;
   localparam logic [3:0]  EG_CODE_DAMP = 4'hE;
   localparam logic [3:0]  EG_CODE_FADE = 4'h9;
   localparam logic [3:0]  EG_CODE_TAIL = 4'h6;
   localparam logic [3:0]  EG_CODE_MAX  = 4'hF;

   // step period exponent for a moving code
   function automatic int eg_rate_shift(input logic [3:0] code,
                                        input logic       is_attack,
                                        input int         base);
      int sh;
      if (code == EG_CODE_MAX)
         sh = base - 2;
      else
         sh = base + (14 - int'(code));
      if (is_attack)
         sh = sh - 1;
      return sh;
   endfunction

endpackage

// File: rtl/eg_rate_sel.sv
module eg_rate_sel
   import eg_pkg::*;
#(
   parameter  int RATE_BASE = 2,
   parameter  int SHIFT_W   = 4
)(
   input  eg_phase_t             phase,
   input  logic [EG_CODE_W-1:0]  atk_rate,
   input  logic [EG_CODE_W-1:0]  dec_rate,
   input  logic [EG_CODE_W-1:0]  rel_rate,
   input  logic                  hold_mode,
   input  logic                  long_tail,
   output logic [SHIFT_W-1:0]    shift,
   output logic                  moves,
   output logic                  instant
);

   logic [EG_CODE_W-1:0] code;
   logic [EG_CODE_W-1:0] off_code;
   logic                 attacking;
   logic                 active;

   always_comb begin
      if (long_tail)
         off_code = EG_CODE_TAIL;
      else if (hold_mode)
         off_code = rel_rate;
      else
         off_code = EG_CODE_FADE;
   end

   always_comb begin
      attacking = 1'b0;
      active    = 1'b1;
      unique case (phase)
         EG_ATTACK: begin
            code      = atk_rate;
            attacking = 1'b1;
         end
         EG_DECAY:   code = dec_rate;
         EG_FALL:    code = rel_rate;
         EG_RELEASE: code = off_code;
         EG_DAMP:    code = EG_CODE_DAMP;
         default: begin
            code   = '0;
            active = 1'b0;
         end
      endcase
   end

   always_comb begin
      moves   = active && (code >= 4'd2);
      instant = attacking && (code == EG_CODE_MAX);
      if (moves && !instant)
         shift = SHIFT_W'(eg_rate_shift(code, attacking, RATE_BASE));
      else
         shift = '0;
   end

endmodule

// File: rtl/eg_prescaler.sv
module eg_prescaler #(
   parameter  int CNT_W   = 15,
   parameter  int SHIFT_W = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_en,
   input  logic [SHIFT_W-1:0] shift,
   input  logic               moves,
   input  logic               instant,
   output logic               step
);

   logic [CNT_W-1:0] tick_q;
   logic [CNT_W-1:0] mask;
   logic             aligned;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_q <= '0;
      else if (sample_en)
         tick_q <= tick_q + 1'b1;
   end

   // low 'shift' bits of the sample counter must all be zero
   always_comb begin
      mask    = ~({CNT_W{1'b1}} << shift);
      aligned = ((tick_q & mask) == '0);
      step    = sample_en && moves && (instant || aligned);
   end

endmodule

// File: rtl/eg_level_fsm.sv
module eg_level_fsm
   import eg_pkg::*;
#(
   parameter  int LVL_BITS = 8,
   parameter  int ENV_W    = LVL_BITS + 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 key_on,
   input  logic                 key_off,
   input  logic                 step,
   input  logic                 instant,
   input  logic                 hold_mode,
   input  logic [3:0]           sus_lvl,
   output eg_phase_t            phase_q,
   output logic [ENV_W-1:0]     env_q
);

   localparam logic [ENV_W-1:0] FULL = ENV_W'(1) << LVL_BITS;

   eg_phase_t          phase_d;
   logic [ENV_W-1:0]   env_d;
   logic [ENV_W-1:0]   sl_target;
   logic [ENV_W-1:0]   env_up;

   assign sl_target = ENV_W'(sus_lvl) << (LVL_BITS - 4);
   assign env_up    = env_q + ENV_W'(step);

   always_comb begin
      phase_d = phase_q;
      env_d   = env_q;
      if (key_on) begin
         phase_d = (phase_q == EG_IDLE) ? EG_ATTACK : EG_DAMP;
      end else if (key_off) begin
         if (phase_q != EG_IDLE && phase_q != EG_RELEASE)
            phase_d = EG_RELEASE;
      end else begin
         unique case (phase_q)
            EG_ATTACK: begin
               if (step) begin
                  if (instant || env_q <= ENV_W'(1)) begin
                     env_d   = '0;
                     phase_d = EG_DECAY;
                  end else begin
                     env_d = env_q - 1'b1;
                  end
               end
            end
            EG_DECAY: begin
               if (env_q >= sl_target)
                  phase_d = hold_mode ? EG_HOLD : EG_FALL;
               else if (step)
                  env_d = env_q + 1'b1;
            end
            EG_FALL, EG_RELEASE, EG_DAMP: begin
               if (env_up >= FULL) begin
                  env_d   = FULL;
                  phase_d = (phase_q == EG_DAMP) ? EG_ATTACK : EG_IDLE;
               end else begin
                  env_d = env_up;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= EG_IDLE;
         env_q   <= FULL;
      end else begin
         phase_q <= phase_d;
         env_q   <= env_d;
      end
   end

endmodule

// File: rtl/eg_out_stage.sv
module eg_out_stage #(
   parameter  int LVL_BITS = 8,
   parameter  int TL_W     = 6,
   parameter  bit REG_OUT  = 1'b0,
   parameter  int ENV_W    = LVL_BITS + 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENV_W-1:0]   env,
   input  logic [TL_W-1:0]    tot_lvl,
   input  logic               stopped,
   output logic [ENV_W-1:0]   atten,
   output logic               idle
);

   localparam int             SUM_W = ENV_W + 1;
   localparam logic [SUM_W-1:0] FULL_S = SUM_W'(1) << LVL_BITS;

   logic [SUM_W-1:0] sum;
   logic [ENV_W-1:0] sat;

   always_comb begin
      sum = SUM_W'(env) + (SUM_W'(tot_lvl) << (LVL_BITS - TL_W));
      sat = (sum >= FULL_S) ? ENV_W'(FULL_S) : sum[ENV_W-1:0];
   end

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               atten <= ENV_W'(FULL_S);
               idle  <= 1'b1;
            end else begin
               atten <= sat;
               idle  <= stopped;
            end
         end
      end else begin : g_comb
         assign atten = sat;
         assign idle  = stopped;
      end
   endgenerate

endmodule

// File: rtl/adsr_env_gen.sv
module adsr_env_gen
   import eg_pkg::*;
#(
   parameter  int RATE_BASE = 2,
   parameter  int LVL_BITS  = 8,
   parameter  int TL_W      = 6,
   parameter  bit REG_OUT   = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_en,
   input  logic              key_on,
   input  logic              key_off,
   input  logic [3:0]        atk_rate,
   input  logic [3:0]        dec_rate,
   input  logic [3:0]        rel_rate,
   input  logic [3:0]        sus_lvl,
   input  logic [TL_W-1:0]   tot_lvl,
   input  logic              hold_mode,
   input  logic              long_tail,
   output logic [LVL_BITS:0] atten,
   output logic              idle
);

   localparam int ENV_W   = LVL_BITS + 1;
   localparam int MAX_SH  = RATE_BASE + 12;
   localparam int CNT_W   = MAX_SH + 1;
   localparam int SHIFT_W = $clog2(CNT_W + 1);

   generate
      if (RATE_BASE < 2) begin : g_bad_base
         $error("RATE_BASE must be at least 2");
      end
      if (LVL_BITS < TL_W || LVL_BITS < 4) begin : g_bad_lvl
         $error("LVL_BITS too small for level fields");
      end
   endgenerate

   eg_phase_t          phase_q;
   logic [ENV_W-1:0]   env_q;
   logic [SHIFT_W-1:0] shift;
   logic               moves;
   logic               instant;
   logic               step;

   eg_rate_sel #(
      .RATE_BASE (RATE_BASE),
      .SHIFT_W   (SHIFT_W)
   ) u_rate (
      .phase     (phase_q),
      .atk_rate  (atk_rate),
      .dec_rate  (dec_rate),
      .rel_rate  (rel_rate),
      .hold_mode (hold_mode),
      .long_tail (long_tail),
      .shift     (shift),
      .moves     (moves),
      .instant   (instant)
   );

   eg_prescaler #(
      .CNT_W   (CNT_W),
      .SHIFT_W (SHIFT_W)
   ) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .shift     (shift),
      .moves     (moves),
      .instant   (instant),
      .step      (step)
   );

   eg_level_fsm #(
      .LVL_BITS (LVL_BITS),
      .ENV_W    (ENV_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_on    (key_on),
      .key_off   (key_off),
      .step      (step),
      .instant   (instant),
      .hold_mode (hold_mode),
      .sus_lvl   (sus_lvl),
      .phase_q   (phase_q),
      .env_q     (env_q)
   );

   eg_out_stage #(
      .LVL_BITS (LVL_BITS),
      .TL_W     (TL_W),
      .REG_OUT  (REG_OUT),
      .ENV_W    (ENV_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .env     (env_q),
      .tot_lvl (tot_lvl),
      .stopped (phase_q == EG_IDLE),
      .atten   (atten),
      .idle    (idle)
   );

endmodule

// File: rtl/eg_env_chk.sv
module eg_env_chk
   import eg_pkg::*;
#(
   parameter  int LVL_BITS = 8,
   parameter  int ENV_W    = LVL_BITS + 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic             key_on,
   input  logic             key_off,
   input  logic [ENV_W-1:0] atten,
   input  logic             idle,
   input  logic [ENV_W-1:0] env,
   input  eg_phase_t        phase
);

   localparam logic [ENV_W-1:0] FULL = ENV_W'(1) << LVL_BITS;

   p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (atten == FULL && env == FULL));

   p_env_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      env <= FULL && atten <= FULL && atten >= env);

   p_no_tick_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable(env));

   p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (env == $past(env) || env == $past(env) + 1'b1 ||
                env + 1'b1 == $past(env) || env == '0));

   p_attack_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      phase == EG_ATTACK |=> env <= $past(env));

   p_hold_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == EG_HOLD && !key_on && !key_off) |=> (phase == EG_HOLD && $stable(env)));

   p_damp_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == EG_DAMP && !key_on && !key_off) |=> (phase == EG_DAMP || phase == EG_ATTACK));

   p_retrigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (key_on && !idle) |=> phase == EG_DAMP);

endmodule

bind adsr_env_gen eg_env_chk #(
   .LVL_BITS (LVL_BITS),
   .ENV_W    (ENV_W)
) u_env_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sample_en (sample_en),
   .key_on    (key_on),
   .key_off   (key_off),
   .atten     (atten),
   .idle      (idle),
   .env       (env_q),
   .phase     (phase_q)
);

// File: tb/adsr_env_gen_tb_top.sv
`timescale 1ns/1ps
module adsr_env_gen_tb_top;

   localparam int BASE = 2;
   localparam int FULL = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_en = 1'b0;
   logic       key_on = 1'b0;
   logic       key_off = 1'b0;
   logic [3:0] atk_rate = 4'd0;
   logic [3:0] dec_rate = 4'd0;
   logic [3:0] rel_rate = 4'd0;
   logic [3:0] sus_lvl = 4'd0;
   logic [5:0] tot_lvl = 6'd0;
   logic       hold_mode = 1'b1;
   logic       long_tail = 1'b0;
   logic [8:0] atten;
   logic       idle;

   int  vectors = 0;
   int  fails = 0;
   int  cyc = 0;
   bit  done = 1'b0;
   bit  rand_se = 1'b0;

   always #2.5 clk = ~clk;

   adsr_env_gen dut_i (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
      .key_on(key_on), .key_off(key_off),
      .atk_rate(atk_rate), .dec_rate(dec_rate), .rel_rate(rel_rate),
      .sus_lvl(sus_lvl), .tot_lvl(tot_lvl),
      .hold_mode(hold_mode), .long_tail(long_tail),
      .atten(atten), .idle(idle)
   );

   // phase numbering of the bench model
   localparam int M_IDLE = 0, M_ATK = 1, M_DEC = 2, M_HOLD = 3,
                  M_FALL = 4, M_REL = 5, M_DAMP = 6;

   int          m_ph;
   int          m_env;
   int unsigned m_n;

   function automatic string tag_of(input int ph);
      case (ph)
         M_ATK:  return "R4";
         M_DEC:  return "R5";
         M_HOLD: return "R6";
         M_FALL: return "R7";
         M_REL:  return "R8";
         M_DAMP: return "R9";
         default: return "R11";
      endcase
   endfunction

   function automatic int period_exp(input int code, input bit atk);
      int e;
      e = (code == 15) ? BASE - 2 : BASE + 14 - code;
      return atk ? e - 1 : e;
   endfunction

   function automatic int expect_att(input int env, input int tl);
      int s;
      s = env + 4 * tl;
      return (s > FULL) ? FULL : s;
   endfunction

   // reference envelope, advanced at each rising edge
   always @(posedge clk or negedge rst_n) begin : model
      int  code;
      bit  go;
      bit  jump;
      if (!rst_n) begin
         m_ph  = M_IDLE;
         m_env = FULL;
         m_n   = 0;
      end else begin
         case (m_ph)
            M_ATK:  code = atk_rate;
            M_DEC:  code = dec_rate;
            M_FALL: code = rel_rate;
            M_REL:  code = long_tail ? 6 : (hold_mode ? int'(rel_rate) : 9);
            M_DAMP: code = 14;
            default: code = 0;
         endcase
         jump = (m_ph == M_ATK) && (code == 15);
         go   = sample_en && (code >= 2) &&
                (jump || (m_n % (32'd1 << period_exp(code, m_ph == M_ATK))) == 0);
         if (key_on) begin
            m_ph = (m_ph == M_IDLE) ? M_ATK : M_DAMP;
         end else if (key_off) begin
            if (m_ph != M_IDLE && m_ph != M_REL) m_ph = M_REL;
         end else begin
            case (m_ph)
               M_ATK: if (go) begin
                  if (jump || m_env <= 1) begin m_env = 0; m_ph = M_DEC; end
                  else m_env = m_env - 1;
               end
               M_DEC: begin
                  if (m_env >= 16 * int'(sus_lvl)) m_ph = hold_mode ? M_HOLD : M_FALL;
                  else if (go) m_env = m_env + 1;
               end
               M_FALL, M_REL, M_DAMP: begin
                  if (go) m_env = m_env + 1;
                  if (m_env >= FULL) begin
                     m_env = FULL;
                     m_ph  = (m_ph == M_DAMP) ? M_ATK : M_IDLE;
                  end
               end
               default: ;
            endcase
         end
         if (sample_en) m_n = m_n + 1;
      end
   end

   // compare every cycle against the model
   always @(negedge clk) begin : cmp
      int ea;
      if (rst_n && !done) begin
         ea = expect_att(m_env, tot_lvl);
         vectors++;
         if (atten !== 9'(ea)) begin
            fails++;
            $display("FAIL %s atten act=%0d exp=%0d", tag_of(m_ph), atten, ea);
         end
         vectors++;
         if (idle !== (m_ph == M_IDLE)) begin
            fails++;
            $display("FAIL %s idle act=%0b exp=%0b", tag_of(m_ph), idle, m_ph == M_IDLE);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sample_en = rand_se ? (($urandom % 4) != 0) : 1'b1;
      end
   endtask

   task automatic strobe_on();
      @(negedge clk); key_on = 1'b1;
      @(negedge clk); key_on = 1'b0;
   endtask

   task automatic strobe_off();
      @(negedge clk); key_off = 1'b1;
      @(negedge clk); key_off = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 atten", atten, 256);
      check("R1 idle", idle, 1);

      // R10: key_off while idle has no effect
      strobe_off();
      check("R10 idle", idle, 1);
      check("R10 atten", atten, 256);

      // R3: attack code 0 never moves
      atk_rate = 4'd0; sample_en = 1'b1;
      strobe_on();
      cycles(200);
      check("R3 atk code0 atten", atten, 256);
      check("R3 atk code0 idle", idle, 0);
      hold_mode = 1'b1; rel_rate = 4'd15;
      strobe_off();
      @(negedge clk);
      check("R11 release at full", idle, 1);

      // R3: instant attack on code 15
      atk_rate = 4'd15; dec_rate = 4'd15; sus_lvl = 4'd1;
      @(negedge clk); key_on = 1'b1;
      @(negedge clk); key_on = 1'b0;
      @(negedge clk);
      check("R3 instant attack", atten, 0);
      cycles(30);
      check("R5 decay to sustain", atten, 16);
      check("R6 hold", atten, 16);
      tot_lvl = 6'd63; #1;
      check("R2 saturate", atten, 256);
      tot_lvl = 6'd10; #1;
      check("R2 sum", atten, 56);
      tot_lvl = 6'd0;

      // R10/R9: simultaneous strobes restart through damping
      atk_rate = 4'd0;
      @(negedge clk); key_on = 1'b1; key_off = 1'b1;
      @(negedge clk); key_on = 1'b0; key_off = 1'b0;
      cycles(1100);
      check("R10 key_on wins idle", idle, 0);
      check("R9 damp reaches full", atten, 256);
      strobe_off();
      cycles(2);

      // random episodes
      rand_se = 1'b1;
      for (int ep = 0; ep < 40; ep++) begin
         atk_rate  = 4'(11 + $urandom % 5);
         dec_rate  = 4'(11 + $urandom % 5);
         rel_rate  = 4'(11 + $urandom % 5);
         sus_lvl   = 4'($urandom % 16);
         tot_lvl   = (($urandom % 3) == 0) ? 6'($urandom % 64) : 6'($urandom % 4);
         hold_mode = 1'($urandom % 2);
         long_tail = (($urandom % 5) == 0);
         if (($urandom % 8) == 0) dec_rate = 4'($urandom % 2);
         strobe_on();
         cycles(50 + $urandom % 1500);
         if (($urandom % 3) == 0) begin
            strobe_on();
            cycles(50 + $urandom % 800);
         end
         strobe_off();
         cycles(100 + $urandom % 1200);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule